// File: doc/BRIEF.md
# Parallel Peripheral Bus Cycle Generator

This block turns single-byte register requests from on-chip logic into complete bus cycles on an 8-bit parallel peripheral bus. A request carries an address, a write byte and a direction flag. The block runs one full read or write cycle on the bus pins. It ends the cycle with a one-clock completion pulse and, for reads, the byte it sampled.

Two static mode pins select one of four pin formats. The first mode pin selects separate address lines or one shared address/data bus with an address-latch enable. The second mode pin selects one of two strobe styles. In the first style, separate active-low read and write strobes are used. In the second style, a read/write level is combined with an active-low data strobe. Each phase lasts a set number of clock cycles, and each phase length is a parameter. The defaults give about 256 ns for a separate-lines transfer and about 280 ns for a shared-bus transfer at 125 MHz. The data pins come out as a split output, an output enable and an input, so the tri-state pad sits outside the block.

The request side is a valid/ready channel. `req_ready` is high only while the bus is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a cycle is running, `req_ready` is low and the request pins are not looked at, so a request that is held waits and a pulse that ends is lost. The completion side gives no back-pressure. `rsp_done` is a single-cycle pulse, and `rsp_rdata` holds the last byte that was read.

Top module: `pbus_host_ctrl`

## Requirements
- R1: `req_ready` is high exactly when `bus_cs_n` is high. A request is taken only on an edge where both `req_valid` and `req_ready` are high. A request raised while a cycle runs starts nothing and does not change that cycle.
- R2: With `mux_mode`=0, `bus_cs_n` goes low in the cycle after acceptance. `bus_addr` then carries the request address for SETUP_CYC cycles before the strobe, for STROBE_CYC strobe cycles, and for HOLD_CYC cycles after the strobe, with `bus_cs_n` still low.
- R3: With `mux_mode`=1, the cycle opens with ALE_CYC cycles in which `bus_ale`=1 and the address is driven on `bus_dout` with `bus_oe`=1. Next come ALE_HOLD_CYC cycles with `bus_ale`=0 and the address still driven. Then come TURN_CYC cycles with `bus_oe`=0, and then the strobe.
- R4: With `moto_mode`=0, `bus_rdn_rw` is the active-low read strobe and `bus_wrn_ds` is the active-low write strobe. During a read only `bus_rdn_rw` goes low, during a write only `bus_wrn_ds` goes low, and the two are never low together.
- R5: With `moto_mode`=1, `bus_rdn_rw` is a direction level (1 = read, 0 = write) held for every cycle in which `bus_cs_n` is low, and 1 when idle. `bus_wrn_ds` is low only during the strobe phase.
- R6: A strobe is active only while `bus_cs_n` is low, and `bus_cs_n` falls at least one cycle before the strobe.
- R7: Write data is driven (`bus_oe`=1, `bus_dout`=write byte) only in the strobe and hold phases of a write. During a read `bus_oe` is 0 except in the shared-bus address phases of R3.
- R8: On a read, `bus_din` is sampled at the edge that ends the last strobe cycle and shown on `rsp_rdata`. That value is held until the next read is sampled. Writes leave `rsp_rdata` unchanged.
- R9: `rsp_done` is high for exactly one cycle, namely the first cycle in which `bus_cs_n` is high again after a transfer.
- R10: A request that is present in the `rsp_done` cycle is accepted at once. `bus_cs_n` is then high for exactly one cycle between the two transfers.
- R11: With `mux_mode`=0, `bus_ale` stays 0. With `mux_mode`=1, `bus_addr` stays 0.
- R12: During and right after reset, `bus_cs_n`, `bus_rdn_rw` and `bus_wrn_ds` are 1, `bus_ale`, `bus_oe`, `rsp_done` and `rsp_rdata` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = shared address/data bus, 0 = separate address lines |
| moto_mode | input | 1 | 1 = direction level plus data strobe, 0 = separate read/write strobes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rdn_rw | output | 1 | Read strobe (active low) or direction level |
| bus_wrn_ds | output | 1 | Write strobe or data strobe, active low |
| bus_ale | output | 1 | Address-latch enable, shared-bus format only |
| bus_addr | output | ADDR_W | Separate address lines |
| bus_dout | output | DATA_W | Data/address value toward the pad |
| bus_oe | output | 1 | Pad output enable |
| bus_din | input | DATA_W | Data from the pad |

## Verification
Two functions can fall in the same cycle. The first is the completion pulse of one transfer. The second is the acceptance of the next request. This is provoked by holding `req_valid` high with a new request while a transfer is still running. The bench then checks that done, the single high cycle of chip select and the new cycle's setup line up as R9 and R10 require. Read capture and strobe release also share an edge. The bench drives `bus_din` with a value that changes every cycle, so a capture one cycle early or late shows up as a wrong byte. The behavioural model predicts every pin on every clock for all four formats.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ALE,
    PH_ALE_HOLD,
    PH_TURN,
    PH_STROBE,
    PH_HOLD
  } pbus_phase_e;

  typedef struct packed {
    logic write;
    logic muxed;
    logic moto;
  } pbus_mode_t;

  function automatic int pbus_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int SETUP_CYC    = 3,
  parameter int ALE_CYC      = 2,
  parameter int ALE_HOLD_CYC = 2,
  parameter int TURN_CYC     = 2,
  parameter int STROBE_CYC   = 25,
  parameter int HOLD_CYC     = 4,
  parameter int CNT_W        = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        muxed,
  output pbus_phase_e phase,
  output logic        last_cycle
);

  pbus_phase_e      phase_q, phase_d;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_zero;

  function automatic logic [CNT_W-1:0] span(pbus_phase_e p);
    unique case (p)
      PH_SETUP:    return CNT_W'(SETUP_CYC - 1);
      PH_ALE:      return CNT_W'(ALE_CYC - 1);
      PH_ALE_HOLD: return CNT_W'(ALE_HOLD_CYC - 1);
      PH_TURN:     return CNT_W'(TURN_CYC - 1);
      PH_STROBE:   return CNT_W'(STROBE_CYC - 1);
      PH_HOLD:     return CNT_W'(HOLD_CYC - 1);
      default:     return '0;
    endcase
  endfunction

  function automatic pbus_phase_e succ(pbus_phase_e p);
    unique case (p)
      PH_SETUP:    return PH_STROBE;
      PH_ALE:      return PH_ALE_HOLD;
      PH_ALE_HOLD: return PH_TURN;
      PH_TURN:     return PH_STROBE;
      PH_STROBE:   return PH_HOLD;
      default:     return PH_IDLE;
    endcase
  endfunction

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = muxed ? PH_ALE : PH_SETUP;
        t_load  = 1'b1;
        t_val   = span(phase_d);
      end
    end else if (t_zero) begin
      phase_d = succ(phase_q);
      t_load  = 1'b1;
      t_val   = span(phase_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  pbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  assign phase      = phase_q;
  assign last_cycle = (phase_q != PH_IDLE) && t_zero;

endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  pbus_phase_e       phase,
  input  pbus_mode_t        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cs_n,
  output logic              rdn_rw,
  output logic              wrn_ds,
  output logic              ale,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);

  logic active, strobe, addr_ph, data_ph;

  always_comb begin
    active  = (phase != PH_IDLE);
    strobe  = (phase == PH_STROBE);
    addr_ph = (phase == PH_ALE) || (phase == PH_ALE_HOLD);
    data_ph = mode.write && ((phase == PH_STROBE) || (phase == PH_HOLD));

    cs_n   = !active;
    ale    = (phase == PH_ALE);
    addr_o = (active && !mode.muxed) ? addr : '0;
    oe     = addr_ph || data_ph;
    if (addr_ph)      dout = DATA_W'(addr);
    else if (data_ph) dout = wdata;
    else              dout = '0;

    if (mode.moto) begin
      rdn_rw = active ? !mode.write : 1'b1;
      wrn_ds = !strobe;
    end else begin
      rdn_rw = !(strobe && !mode.write);
      wrn_ds = !(strobe && mode.write);
    end
  end

endmodule

// File: rtl/pbus_rsp.sv
module pbus_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  input  logic              finish,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      if (capture) rdata <= din;
      done <= finish;
    end
  end

endmodule

// File: rtl/pbus_host_ctrl.sv
module pbus_host_ctrl
  import pbus_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int SETUP_CYC    = 3,
  parameter int ALE_CYC      = 2,
  parameter int ALE_HOLD_CYC = 2,
  parameter int TURN_CYC     = 2,
  parameter int STROBE_CYC   = 25,
  parameter int HOLD_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              moto_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_rdn_rw,
  output logic              bus_wrn_ds,
  output logic              bus_ale,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);

  localparam int MAX_SPAN = pbus_max(pbus_max(pbus_max(SETUP_CYC, ALE_CYC),
                                              pbus_max(ALE_HOLD_CYC, TURN_CYC)),
                                     pbus_max(STROBE_CYC, HOLD_CYC));
  localparam int CNT_W    = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1;

  pbus_phase_e       phase;
  logic              last_cycle;
  logic              accept;
  pbus_mode_t        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mode_q  <= '{write: req_write, muxed: mux_mode, moto: moto_mode};
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  pbus_seq #(
    .SETUP_CYC    (SETUP_CYC),
    .ALE_CYC      (ALE_CYC),
    .ALE_HOLD_CYC (ALE_HOLD_CYC),
    .TURN_CYC     (TURN_CYC),
    .STROBE_CYC   (STROBE_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .muxed      (mux_mode),
    .phase      (phase),
    .last_cycle (last_cycle)
  );

  pbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase  (phase),
    .mode   (mode_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .cs_n   (bus_cs_n),
    .rdn_rw (bus_rdn_rw),
    .wrn_ds (bus_wrn_ds),
    .ale    (bus_ale),
    .addr_o (bus_addr),
    .dout   (bus_dout),
    .oe     (bus_oe)
  );

  pbus_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture ((phase == PH_STROBE) && last_cycle && !mode_q.write),
    .din     (bus_din),
    .finish  ((phase == PH_HOLD) && last_cycle),
    .rdata   (rsp_rdata),
    .done    (rsp_done)
  );

endmodule

// File: rtl/pbus_host_ctrl_chk.sv
module pbus_host_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mux_mode,
  input logic moto_mode,
  input logic req_ready,
  input logic rsp_done,
  input logic bus_cs_n,
  input logic bus_rdn_rw,
  input logic bus_wrn_ds,
  input logic bus_ale,
  input logic bus_oe
);

  logic strobe_any;
  assign strobe_any = moto_mode ? !bus_wrn_ds : (!bus_rdn_rw || !bus_wrn_ds);

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n);

  a_r3_ale_drives_lines: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_oe && !bus_cs_n));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !moto_mode |-> !(!bus_rdn_rw && !bus_wrn_ds));

  a_r6_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> !bus_cs_n);

  a_r6_cs_leads_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> !strobe_any);

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!moto_mode && !bus_rdn_rw) |-> !bus_oe);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(bus_cs_n));

  a_r9_release_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_done);

  a_r11_ale_only_muxed: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> mux_mode);

endmodule

bind pbus_host_ctrl pbus_host_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mux_mode   (mux_mode),
  .moto_mode  (moto_mode),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .bus_cs_n   (bus_cs_n),
  .bus_rdn_rw (bus_rdn_rw),
  .bus_wrn_ds (bus_wrn_ds),
  .bus_ale    (bus_ale),
  .bus_oe     (bus_oe)
);

// File: tb/pbus_host_ctrl_bench.sv
`timescale 1ns/1ps
module pbus_host_ctrl_bench;

  localparam int AW = 8, DW = 8;
  localparam int SU = 3, AL = 2, AH = 2, TU = 2, ST = 25, HO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_mode = 1'b0, moto_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] bus_din = '0;
  logic req_ready, rsp_done, bus_cs_n, bus_rdn_rw, bus_wrn_ds, bus_ale, bus_oe;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  always #4 clk = ~clk;

  pbus_host_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .ALE_CYC(AL), .ALE_HOLD_CYC(AH),
    .TURN_CYC(TU), .STROBE_CYC(ST), .HOLD_CYC(HO)
  ) u_pbus_host_ctrl (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .moto_mode(moto_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n), .bus_rdn_rw(bus_rdn_rw),
    .bus_wrn_ds(bus_wrn_ds), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 0, run_cmp = 0;

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_wr, m_mux, m_moto, m_done;
  int m_t;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  function automatic int pre_len(bit mx);
    return mx ? (AL + AH + TU) : SU;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_done = 0; m_rdata = '0;
      m_wr = 0; m_mux = 0; m_moto = 0; m_addr = '0; m_wdata = '0;
    end else begin
      cyc++;
      m_done = 0;
      if (m_busy) begin
        if (!m_wr && m_t == pre_len(m_mux) + ST - 1) m_rdata = bus_din;
        m_t++;
        if (m_t == pre_len(m_mux) + ST + HO) begin
          m_busy = 0; m_done = 1;
        end
      end else if (req_valid) begin
        m_busy = 1; m_t = 0; m_wr = req_write; m_mux = mux_mode; m_moto = moto_mode;
        m_addr = req_addr; m_wdata = req_wdata;
      end
      if (cyc > 150000 && !fin) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
      end
    end
  end

  // peripheral side: data input changes every cycle
  always @(negedge clk) bus_din <= DW'(cyc * 37 + 11);

  int hi_run = 0, last_gap = 0;

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      automatic int pre = pre_len(m_mux);
      automatic bit strb = m_busy && m_t >= pre && m_t < pre + ST;
      automatic bit aph  = m_busy && m_mux && m_t < AL + AH;
      automatic bit dph  = m_busy && m_wr && m_t >= pre;
      automatic bit e_rd = m_moto ? (m_busy ? !m_wr : 1'b1) : !(strb && !m_wr);
      automatic bit e_wd = m_moto ? !strb : !(strb && m_wr);
      chk("R1 req_ready", req_ready, !m_busy);
      chk("R6 bus_cs_n", bus_cs_n, !m_busy);
      chk(m_mux ? "R11 bus_addr" : "R2 bus_addr", bus_addr, (m_busy && !m_mux) ? m_addr : 0);
      chk(m_mux ? "R3 bus_ale" : "R11 bus_ale", bus_ale, m_busy && m_mux && m_t < AL);
      chk(m_moto ? "R5 bus_rdn_rw" : "R4 bus_rdn_rw", bus_rdn_rw, e_rd);
      chk(m_moto ? "R5 bus_wrn_ds" : "R4 bus_wrn_ds", bus_wrn_ds, e_wd);
      chk(aph ? "R3 bus_oe" : "R7 bus_oe", bus_oe, aph || dph);
      if (aph) chk("R3 bus_dout address", bus_dout, m_addr);
      else if (dph) chk("R7 bus_dout data", bus_dout, m_wdata);
      chk("R8 rsp_rdata", rsp_rdata, m_rdata);
      chk("R9 rsp_done", rsp_done, m_done);
    end
    if (rst_n) begin
      if (bus_cs_n) hi_run++;
      else if (hi_run > 0) begin last_gap = hi_run; hi_run = 0; end
    end
  end

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic set_mode(bit mx, bit mt);
    wait_idle();
    mux_mode = mx; moto_mode = mt;
  endtask

  task automatic send(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: state held in reset
    chk("R12 cs in reset", bus_cs_n, 1);
    chk("R12 strobes in reset", {bus_rdn_rw, bus_wrn_ds}, 2'b11);
    chk("R12 ale/oe/done in reset", {bus_ale, bus_oe, rsp_done}, 0);
    chk("R12 rdata in reset", rsp_rdata, 0);
    chk("R12 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", req_ready, 1);
    chk("R12 cs after reset", bus_cs_n, 1);
    run_cmp = 1;

    for (int mode = 0; mode < 4; mode++) begin
      set_mode(mode[0], mode[1]);
      send(1, 8'h3C, 8'hA5);
      send(0, 8'h81, 8'h00);
      send(1, 8'hFF, 8'h00);
      send(0, 8'h00, 8'hFF);
      send(1, 8'h00, 8'hFF);
      wait_idle();
      chk("R10 chip-select gap between chained transfers", last_gap, 1);
      repeat (2) @(negedge clk);
      send(0, 8'h5A, 8'h00);
      // R1: request while busy is ignored
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hEE; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R1 busy request started nothing", bus_cs_n, 1);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule